// File: doc/BRIEF.md
# Display Memory Host Write Address Sequencer

This block produces the row and column addresses for host writes into a display memory of 80 lines by 104 columns. The host sets the current line and the current column with two separate load strobes. After that it issues a stream of data writes, and the block moves the column forward after each one. A write that completes a line can either leave the column parked at the last column or, when wrap is enabled, return the column to zero and step the line. The line steps upward or downward as the host selects, and it wraps around at both ends of the memory.

The block always outputs the logical line and column. It also outputs the physical column and a linear memory address, and a column-mirror control decides how the logical column maps to the physical one. The memory itself is outside this block and so is command decoding. The addresses are registered state, so the address shown in the cycle of a write is the location that write targets.

Top module: `disp_wr_addr_seq`

## Requirements
- R1: After reset the logical line is 0 and the logical column is 0.
- R2: With wrap disabled, a write at column 103 leaves the column at 103 and the line unchanged. A write at any lower column adds one to the column.
- R3: With wrap enabled, a write at column 103 sets the column to 0 and steps the line in the same update. A write at any lower column adds one to the column and leaves the line unchanged.
- R4: On an end-of-line step, `row_dn` = 0 adds one to the line and `row_dn` = 1 subtracts one from it.
- R5: A line step wraps at the memory ends: stepping up from 79 gives 0, and stepping down from 0 gives 79.
- R6: The physical column is 103 minus the logical column while `mirror_en` = 1, and equals the logical column while `mirror_en` = 0. The linear address is line × 104 + physical column.
- R7: Changing `mirror_en` never changes the logical line or column. It affects only the physical column and the linear address of later writes.
- R8: A load strobe makes its value visible at the output one clock later. Line and column load independently, and the address shown after a load is the one the next write uses.
- R9: In any cycle where either load strobe is high, a write strobe advances nothing.
- R10: A loaded line above 79 is stored as 79, and a loaded column above 103 is stored as 103.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_ld | input | 1 | Load the line from `row_val` |
| row_val | input | 7 | Line value to load |
| col_ld | input | 1 | Load the column from `col_val` |
| col_val | input | 7 | Column value to load |
| wr_stb | input | 1 | Host data write accepted this cycle |
| wrap_en | input | 1 | 1: the column returns to 0 and the line steps at end of line |
| row_dn | input | 1 | 1: the line steps downward, 0: upward |
| mirror_en | input | 1 | 1: the physical column is reversed |
| row_o | output | 7 | Logical line |
| col_o | output | 7 | Logical column |
| phys_col_o | output | 7 | Physical column sent to memory |
| lin_addr_o | output | 14 | Linear memory address |

## Verification
If the column state is wrong, it appears on `col_o`, `phys_col_o` and `lin_addr_o` in the very next cycle. A fault in the column-end step or the line step, however, appears only in the cycle after a write at column 103. Faults at the line boundaries appear only in the cycle after a wrap-enabled write at line 0 or line 79. The bench therefore compares against a model on every cycle of a long mixed-control run. It also steers directed writes onto each boundary, so that such a fault shows up one clock after the triggering write.

// File: rtl/dwa_pkg.sv
package dwa_pkg;
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } line_dir_e;
endpackage

// File: rtl/dwa_col_ctr.sv
module dwa_col_ctr #(
   parameter int COLS = 104,
   parameter int CW   = $clog2(COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   input  logic          hold,
   input  logic          wr,
   input  logic          wrap_en,
   output logic [CW-1:0] col,
   output logic          line_step
);
   localparam logic [CW-1:0] MAXC = CW'(COLS - 1);

   logic [CW-1:0] col_q, col_nxt, ld_clamp;
   logic          at_end;

   assign ld_clamp = (ld_val > MAXC) ? MAXC : ld_val;
   assign at_end   = (col_q == MAXC);

   always_comb begin
      col_nxt   = col_q;
      line_step = 1'b0;
      if (ld) begin
         col_nxt = ld_clamp;
      end else if (wr && !hold) begin
         if (!at_end) begin
            col_nxt = col_q + CW'(1);
         end else if (wrap_en) begin
            col_nxt   = '0;
            line_step = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) col_q <= '0;
      else        col_q <= col_nxt;
   end

   assign col = col_q;
endmodule

// File: rtl/dwa_row_ctr.sv
module dwa_row_ctr
   import dwa_pkg::*;
#(
   parameter int ROWS = 80,
   parameter int RW   = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [RW-1:0] ld_val,
   input  logic          step,
   input  line_dir_e     dir,
   output logic [RW-1:0] row
);
   localparam logic [RW-1:0] MAXR = RW'(ROWS - 1);
   localparam bit POW2 = ((1 << RW) == ROWS);

   logic [RW-1:0] row_q, row_nxt, ld_clamp, row_up, row_down;

   assign ld_clamp = (ld_val > MAXR) ? MAXR : ld_val;

   generate
      if (POW2) begin : g_natural_wrap
         assign row_up   = row_q + RW'(1);
         assign row_down = row_q - RW'(1);
      end else begin : g_compare_wrap
         assign row_up   = (row_q == MAXR)  ? '0   : row_q + RW'(1);
         assign row_down = (row_q == '0)    ? MAXR : row_q - RW'(1);
      end
   endgenerate

   always_comb begin
      row_nxt = row_q;
      if (ld)        row_nxt = ld_clamp;
      else if (step) row_nxt = (dir == DIR_DOWN) ? row_down : row_up;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_q <= '0;
      else        row_q <= row_nxt;
   end

   assign row = row_q;
endmodule

// File: rtl/dwa_addr_map.sv
module dwa_addr_map #(
   parameter int ROWS           = 80,
   parameter int COLS           = 104,
   parameter int RW             = $clog2(ROWS),
   parameter int CW             = $clog2(COLS),
   parameter int AW             = $clog2(ROWS * COLS),
   parameter bit MIRROR_SUPPORT = 1'b1
) (
   input  logic [RW-1:0] row,
   input  logic [CW-1:0] col,
   input  logic          mirror_en,
   output logic [CW-1:0] phys_col,
   output logic [AW-1:0] lin_addr
);
   localparam logic [CW-1:0] MAXC = CW'(COLS - 1);

   generate
      if (MIRROR_SUPPORT) begin : g_mirror
         assign phys_col = mirror_en ? (MAXC - col) : col;
      end else begin : g_direct
         logic unused_mirror;
         assign unused_mirror = mirror_en;
         assign phys_col      = col;
      end
   endgenerate

   assign lin_addr = AW'(row) * AW'(COLS) + AW'(phys_col);
endmodule

// File: rtl/disp_wr_addr_seq.sv
module disp_wr_addr_seq
   import dwa_pkg::*;
#(
   parameter int ROWS           = 80,
   parameter int COLS           = 104,
   parameter bit MIRROR_SUPPORT = 1'b1,
   parameter int RW             = $clog2(ROWS),
   parameter int CW             = $clog2(COLS),
   parameter int AW             = $clog2(ROWS * COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          row_ld,
   input  logic [RW-1:0] row_val,
   input  logic          col_ld,
   input  logic [CW-1:0] col_val,
   input  logic          wr_stb,
   input  logic          wrap_en,
   input  logic          row_dn,
   input  logic          mirror_en,
   output logic [RW-1:0] row_o,
   output logic [CW-1:0] col_o,
   output logic [CW-1:0] phys_col_o,
   output logic [AW-1:0] lin_addr_o
);
   generate
      if (ROWS < 2)  begin : g_bad_rows $error("ROWS must be at least 2"); end
      if (COLS < 2)  begin : g_bad_cols $error("COLS must be at least 2"); end
      if ((1 << RW) < ROWS) begin : g_bad_rw $error("RW too narrow for ROWS"); end
      if ((1 << CW) < COLS) begin : g_bad_cw $error("CW too narrow for COLS"); end
      if ((1 << AW) < ROWS * COLS) begin : g_bad_aw $error("AW too narrow"); end
   endgenerate

   logic      any_ld, line_step;
   line_dir_e dir;

   assign any_ld = row_ld | col_ld;
   assign dir    = row_dn ? DIR_DOWN : DIR_UP;

   dwa_col_ctr #(.COLS(COLS), .CW(CW)) u_col (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (col_ld),
      .ld_val    (col_val),
      .hold      (any_ld),
      .wr        (wr_stb),
      .wrap_en   (wrap_en),
      .col       (col_o),
      .line_step (line_step)
   );

   dwa_row_ctr #(.ROWS(ROWS), .RW(RW)) u_row (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (row_ld),
      .ld_val (row_val),
      .step   (line_step),
      .dir    (dir),
      .row    (row_o)
   );

   dwa_addr_map #(
      .ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW), .AW(AW),
      .MIRROR_SUPPORT(MIRROR_SUPPORT)
   ) u_map (
      .row       (row_o),
      .col       (col_o),
      .mirror_en (mirror_en),
      .phys_col  (phys_col_o),
      .lin_addr  (lin_addr_o)
   );
endmodule

// File: rtl/dwa_chk.sv
module dwa_chk #(
   parameter int ROWS           = 80,
   parameter int COLS           = 104,
   parameter bit MIRROR_SUPPORT = 1'b1,
   parameter int RW             = $clog2(ROWS),
   parameter int CW             = $clog2(COLS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          row_ld,
   input logic [RW-1:0] row_val,
   input logic          col_ld,
   input logic [CW-1:0] col_val,
   input logic          wr_stb,
   input logic          wrap_en,
   input logic          row_dn,
   input logic          mirror_en,
   input logic [RW-1:0] row_o,
   input logic [CW-1:0] col_o,
   input logic [CW-1:0] phys_col_o
);
   localparam logic [RW-1:0] MAXR = RW'(ROWS - 1);
   localparam logic [CW-1:0] MAXC = CW'(COLS - 1);

   logic eol_wr;
   assign eol_wr = wr_stb && wrap_en && !row_ld && !col_ld && (col_o == MAXC);

   // R10
   range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_o <= MAXR) && (col_o <= MAXC));

   // R2
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !wrap_en && !row_ld && !col_ld && col_o == MAXC)
      |=> (col_o == MAXC) && (row_o == $past(row_o)));

   // R3
   line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eol_wr |=> (col_o == '0));

   // R4
   row_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eol_wr && !row_dn && row_o != MAXR) |=> (row_o == $past(row_o) + RW'(1)));

   // R5
   row_top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eol_wr && !row_dn && row_o == MAXR) |=> (row_o == '0));

   // R5
   row_bot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eol_wr && row_dn && row_o == '0) |=> (row_o == MAXR));

   // R8
   col_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_ld |=> (col_o == (($past(col_val) > MAXC) ? MAXC : $past(col_val))));

   // R9
   ld_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_ld && !col_ld) |=> $stable(col_o));

   // R7
   mirror_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && !row_ld && !col_ld) |=> $stable(col_o) && $stable(row_o));

   generate
      if (MIRROR_SUPPORT) begin : g_mir_chk
         // R6
         mirror_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mirror_en |-> ({1'b0, phys_col_o} + {1'b0, col_o} == {1'b0, MAXC}));
      end
   endgenerate
endmodule

bind disp_wr_addr_seq dwa_chk #(
   .ROWS(ROWS), .COLS(COLS), .MIRROR_SUPPORT(MIRROR_SUPPORT), .RW(RW), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .row_ld(row_ld), .row_val(row_val),
   .col_ld(col_ld), .col_val(col_val), .wr_stb(wr_stb), .wrap_en(wrap_en),
   .row_dn(row_dn), .mirror_en(mirror_en), .row_o(row_o), .col_o(col_o),
   .phys_col_o(phys_col_o)
);

// File: tb/disp_wr_addr_seq_tb.sv
`timescale 1ns/1ps
module disp_wr_addr_seq_tb;
   localparam int ROWS = 80, COLS = 104, RW = 7, CW = 7, AW = 14;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, row_ld, col_ld, wr_stb, wrap_en, row_dn, mirror_en;
   logic [RW-1:0] row_val;
   logic [CW-1:0] col_val;
   logic [RW-1:0] row_o;
   logic [CW-1:0] col_o, phys_col_o;
   logic [AW-1:0] lin_addr_o;

   disp_wr_addr_seq u_dut (
      .clk(clk), .rst_n(rst_n), .row_ld(row_ld), .row_val(row_val),
      .col_ld(col_ld), .col_val(col_val), .wr_stb(wr_stb), .wrap_en(wrap_en),
      .row_dn(row_dn), .mirror_en(mirror_en), .row_o(row_o), .col_o(col_o),
      .phys_col_o(phys_col_o), .lin_addr_o(lin_addr_o)
   );

   int total = 0, bad = 0;
   int er = 0, ec = 0;
   bit done = 0;

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_all(string req);
      int pc;
      pc = mirror_en ? (COLS - 1 - ec) : ec;
      chk({req, " row"}, int'(row_o), er);
      chk({req, " col"}, int'(col_o), ec);
      chk({req, " phys (R6)"}, int'(phys_col_o), pc);
      chk({req, " lin (R6)"}, int'(lin_addr_o), er * COLS + pc);
   endtask

   // one clock: drive on the falling edge, update model at rising edge, sample 1 ns later
   task automatic op(bit rl, int rv, bit cl, int cv, bit w, bit wp, bit dn, bit mir);
      @(negedge clk);
      row_ld = rl; row_val = RW'(rv); col_ld = cl; col_val = CW'(cv);
      wr_stb = w; wrap_en = wp; row_dn = dn; mirror_en = mir;
      @(posedge clk);
      if (rl || cl) begin
         if (rl) er = (rv > ROWS - 1) ? ROWS - 1 : rv;
         if (cl) ec = (cv > COLS - 1) ? COLS - 1 : cv;
      end else if (w) begin
         if (ec != COLS - 1) ec++;
         else if (wp) begin
            ec = 0;
            if (dn) er = (er == 0) ? ROWS - 1 : er - 1;
            else    er = (er == ROWS - 1) ? 0 : er + 1;
         end
      end
      #1;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      bit mir;
      rst_n = 0; row_ld = 0; col_ld = 0; row_val = '0; col_val = '0;
      wr_stb = 0; wrap_en = 0; row_dn = 0; mirror_en = 0;
      repeat (3) @(posedge clk);
      #1;
      check_all("R1 reset");
      @(negedge clk); rst_n = 1;
      #1; check_all("R1 after release");

      // R8 R10 R6: every loadable column and line, mirror alternating
      for (int c = 0; c < 128; c++) begin
         op(0, 0, 1, c, 0, 0, 0, c[0]);
         check_all("R8 R10 col load");
      end
      for (int r = 0; r < 128; r++) begin
         op(1, r, 0, 0, 0, 0, 0, r[1]);
         check_all("R8 R10 row load");
      end

      // R2: saturation with wrap off
      op(1, 37, 1, 100, 0, 0, 0, 0);
      for (int k = 0; k < 6; k++) begin
         op(0, 0, 0, 0, 1, 0, k[0], 0);
         check_all("R2 saturate");
      end

      // R3 R4 R5: upward wrap at the top line
      op(1, 79, 1, 102, 0, 1, 0, 0);
      op(0, 0, 0, 0, 1, 1, 0, 0); check_all("R3 step to end");
      op(0, 0, 0, 0, 1, 1, 0, 0); check_all("R5 up wrap 79->0");
      op(1, 40, 1, 103, 0, 1, 0, 0);
      op(0, 0, 0, 0, 1, 1, 0, 0); check_all("R4 up step");
      op(1, 40, 1, 103, 0, 1, 1, 0);
      op(0, 0, 0, 0, 1, 1, 1, 0); check_all("R4 down step");
      op(1, 0, 1, 103, 0, 1, 1, 1);
      op(0, 0, 0, 0, 1, 1, 1, 1); check_all("R5 down wrap 0->79");

      // R9: load and write together
      op(1, 5, 1, 7, 0, 1, 0, 0);
      op(0, 0, 1, 50, 1, 1, 0, 0); check_all("R9 col load beats write");
      op(1, 9, 0, 0, 1, 1, 0, 0);  check_all("R9 row load freezes col");
      op(1, 60, 1, 103, 0, 1, 0, 0);
      op(1, 60, 0, 0, 1, 1, 0, 0); check_all("R9 no end-of-line step");

      // R7: mirror toggling leaves logical address alone
      op(1, 12, 1, 10, 0, 0, 0, 0);
      for (int k = 0; k < 6; k++) begin
         op(0, 0, 0, 0, 0, 1, 0, k[0]);
         check_all("R7 mirror toggle");
      end

      // mixed run over all controls, compared every cycle
      lfsr = 16'hACE1;
      mir = 0;
      for (int n = 0; n < 30000; n++) begin
         bit rl, cl;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rl = (lfsr[5:0] == 6'd0);
         cl = (lfsr[6:1] == 6'd3);
         if (lfsr[9:4] == 6'd9) mir = ~mir;
         op(rl, int'(lfsr[14:8]), cl, int'(lfsr[15:9]), lfsr[2] | lfsr[3],
            (n % 4000) < 3000, (n / 9000) % 2 == 1, mir);
         check_all("R2 R3 R4 R5 R9 mixed");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule